// File: doc/BRIEF.md
# Register Renamer with Move Elimination

The block is the rename stage of a small out-of-order core. Each cycle it takes a group of up to `NLANE` decoded micro-ops. Each op carries a destination, two sources, a move flag and an operand-size code. The block replaces every logical register number with a physical tag. A register-to-register move that qualifies is not given a new physical register: its destination is pointed at the physical register already holding the source. The move is then complete at rename and leaves no work for any execution unit. Its result reaches dependent ops in the same group with no latency.

Because several logical registers may share one physical register, the block keeps a reference count for each physical register. A new mapping or an eliminated move adds one to the count of its target. A commit port, driven by the in-order retirement logic with the old tag that rename reported for the retired op, subtracts one. A physical register is free exactly when its count is zero. Free registers are handed out lowest-numbered first.

The input group is a valid/ready stream. `in_ready` is computed from the offered group, so a source must hold its data stable while `in_valid` is high and `in_ready` is low. The renamed group is a registered valid/ready stream. While `out_valid` is high and `out_ready` is low, the output holds its value and no new group is accepted. Commit ports carry no handshake and are always taken. `NLOG` must be a power of two.

Top module: `rn_top`

## Requirements
- R1: After reset, logical register i maps to physical register i. Registers NLOG to NPHYS-1 are free, `out_valid` is 0, and an empty group is accepted (`in_ready` = 1).
- R2: Each valid lane with a destination that is not eliminated gets a free physical register. The lanes of one group take the free registers in ascending order of register number, in lane order.
- R3: A lane is eliminated when four conditions all hold: it is valid, it has a destination, its move flag is set, and its size code qualifies. Its destination tag then equals its source-1 tag, `out_elim` is 1, and no register is allocated.
- R4: A move whose destination equals its source-1 register is never eliminated. It is allocated like an ordinary op.
- R5: Size codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit, 4 = 128-bit vector and 5 = 256-bit vector. Only codes 2 to 5 qualify for elimination. A code 0 or 1 move needs a free register.
- R6: Within a group, a source of lane j reads the mapping written by the latest earlier lane with that destination. This includes a move that copies an eliminated move in the same group.
- R7: `out_old_tag` is the mapping of the destination just before the op, including mappings made by earlier lanes of the same group.
- R8: If the free registers cannot cover every non-eliminated destination of the offered group, `in_ready` is 0 and the whole group is held: no mapping and no count changes.
- R9: A commit of tag t lowers its count by one. A register shared by several mappings stays allocated until as many commits as references have arrived. A commit takes effect even in a cycle where rename stalls.
- R10: While `out_valid` = 1 and `out_ready` = 0, the output group stays unchanged and `in_ready` is 0.
- R11: An accepted group appears on the outputs with `out_valid` = 1 at the first clock edge after acceptance. `out_valid` falls after an edge with no acceptance when `out_ready` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input group offered |
| in_ready | output | 1 | Group accepted at this edge |
| in_lane_valid | input | NLANE | Lane holds a micro-op |
| in_dst_en | input | NLANE | Lane writes a destination |
| in_is_move | input | NLANE | Lane is a register-to-register move |
| in_size | input | NLANE x 3 | Operand-size code per lane |
| in_dst | input | NLANE x LW | Logical destination |
| in_src1 | input | NLANE x LW | Logical source 1 (move source) |
| in_src2 | input | NLANE x LW | Logical source 2 |
| cmt_valid | input | NCMT | Commit port active |
| cmt_tag | input | NCMT x PW | Physical tag whose reference is released |
| out_valid | output | 1 | Renamed group present |
| out_ready | input | 1 | Downstream takes the group |
| out_lane_valid | output | NLANE | Renamed lane holds a micro-op |
| out_has_dst | output | NLANE | Renamed lane writes a destination |
| out_elim | output | NLANE | Lane finished at rename as a move |
| out_dst_tag | output | NLANE x PW | New physical destination |
| out_src1_tag | output | NLANE x PW | Physical source 1 |
| out_src2_tag | output | NLANE x PW | Physical source 2 |
| out_old_tag | output | NLANE x PW | Previous mapping of the destination |

## Verification
`in_ready` depends only on the offered group, the current counts and the output hold, so it is read one time step after the inputs change, before the next edge. Renamed tags, `out_elim` and `out_valid` come from one register stage and are read at the falling edge after the accepting rising edge. A commit changes the free set one edge later, so the bench checks its effect on the following group's allocation or stall. The hold under back-pressure is checked over two successive falling edges.

// File: rtl/rn_pkg.sv
`timescale 1ns/1ps
package rn_pkg;
  localparam logic [2:0] SZ_B8   = 3'd0;
  localparam logic [2:0] SZ_B16  = 3'd1;
  localparam logic [2:0] SZ_I32  = 3'd2;
  localparam logic [2:0] SZ_I64  = 3'd3;
  localparam logic [2:0] SZ_V128 = 3'd4;
  localparam logic [2:0] SZ_V256 = 3'd5;

  // full-width register sizes that may share a physical register
  function automatic logic size_wide(input logic [2:0] sz);
    return (sz >= SZ_I32) && (sz <= SZ_V256);
  endfunction
endpackage

// File: rtl/rn_refcnt.sv
`timescale 1ns/1ps
module rn_refcnt #(
  parameter int NPHYS = 168,
  parameter int NLOG  = 16,
  parameter int NLANE = 6,
  parameter int NCMT  = 4,
  parameter int REFW  = 8,
  localparam int PW = $clog2(NPHYS),
  localparam int CW = $clog2(NLANE + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       take,
  input  logic [NLANE-1:0]           lane_wr,
  input  logic [NLANE-1:0][PW-1:0]   lane_tag,
  input  logic [NCMT-1:0]            cmt_valid,
  input  logic [NCMT-1:0][PW-1:0]    cmt_tag,
  output logic [NLANE-1:0][PW-1:0]   pick,
  output logic [CW-1:0]              avail,
  output logic [NPHYS-1:0]           ref_free
);
  logic [REFW-1:0] refs    [NPHYS];
  logic [REFW-1:0] refs_nx [NPHYS];

  always_comb begin
    for (int p = 0; p < NPHYS; p++) begin
      refs_nx[p] = refs[p];
      for (int j = 0; j < NLANE; j++)
        if (take && lane_wr[j] && lane_tag[j] == PW'(p))
          refs_nx[p] = refs_nx[p] + REFW'(1);
      for (int c = 0; c < NCMT; c++)
        if (cmt_valid[c] && cmt_tag[c] == PW'(p))
          refs_nx[p] = refs_nx[p] - REFW'(1);
    end
  end

  for (genvar p = 0; p < NPHYS; p++) begin : g_free
    assign ref_free[p] = (refs[p] == '0);
  end

  // lowest-numbered free registers, first one to lane slot 0
  always_comb begin
    avail = '0;
    pick  = '0;
    for (int p = 0; p < NPHYS; p++) begin
      if (ref_free[p]) begin
        for (int j = 0; j < NLANE; j++)
          if (avail == CW'(j)) pick[j] = PW'(p);
        if (avail != CW'(NLANE)) avail = avail + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPHYS; p++)
        refs[p] <= (p < NLOG) ? REFW'(1) : '0;
    end else begin
      refs <= refs_nx;
    end
  end
endmodule

// File: rtl/rn_map.sv
`timescale 1ns/1ps
module rn_map #(
  parameter int NPHYS = 168,
  parameter int NLOG  = 16,
  parameter int NLANE = 6,
  localparam int PW = $clog2(NPHYS),
  localparam int LW = $clog2(NLOG),
  localparam int CW = $clog2(NLANE + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       take,
  input  logic [NLANE-1:0]           lane_wr,
  input  logic [NLANE-1:0]           elim,
  input  logic [NLANE-1:0][LW-1:0]   dst,
  input  logic [NLANE-1:0][LW-1:0]   src1,
  input  logic [NLANE-1:0][LW-1:0]   src2,
  input  logic [NLANE-1:0][PW-1:0]   pick,
  output logic [NLANE-1:0][PW-1:0]   new_tag,
  output logic [NLANE-1:0][PW-1:0]   s1_tag,
  output logic [NLANE-1:0][PW-1:0]   s2_tag,
  output logic [NLANE-1:0][PW-1:0]   old_tag
);
  logic [PW-1:0] map [NLOG];
  logic [PW-1:0] tmp [NLOG];
  logic [CW-1:0] slot;

  // lanes walk in program order over a working copy of the table
  always_comb begin
    tmp     = map;
    slot    = '0;
    new_tag = '0;
    old_tag = '0;
    s1_tag  = '0;
    s2_tag  = '0;
    for (int j = 0; j < NLANE; j++) begin
      s1_tag[j] = tmp[src1[j]];
      s2_tag[j] = tmp[src2[j]];
      if (lane_wr[j]) begin
        old_tag[j] = tmp[dst[j]];
        if (elim[j]) begin
          new_tag[j] = s1_tag[j];
        end else begin
          for (int q = 0; q < NLANE; q++)
            if (slot == CW'(q)) new_tag[j] = pick[q];
          slot = slot + CW'(1);
        end
        tmp[dst[j]] = new_tag[j];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLOG; i++) map[i] <= PW'(i);
    end else if (take) begin
      map <= tmp;
    end
  end
endmodule

// File: rtl/rn_top.sv
`timescale 1ns/1ps
module rn_top #(
  parameter int NPHYS = 168,
  parameter int NLOG  = 16,
  parameter int NLANE = 6,
  parameter int NCMT  = 4,
  parameter int REFW  = 8,
  localparam int PW = $clog2(NPHYS),
  localparam int LW = $clog2(NLOG),
  localparam int CW = $clog2(NLANE + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [NLANE-1:0]           in_lane_valid,
  input  logic [NLANE-1:0]           in_dst_en,
  input  logic [NLANE-1:0]           in_is_move,
  input  logic [NLANE-1:0][2:0]      in_size,
  input  logic [NLANE-1:0][LW-1:0]   in_dst,
  input  logic [NLANE-1:0][LW-1:0]   in_src1,
  input  logic [NLANE-1:0][LW-1:0]   in_src2,
  input  logic [NCMT-1:0]            cmt_valid,
  input  logic [NCMT-1:0][PW-1:0]    cmt_tag,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [NLANE-1:0]           out_lane_valid,
  output logic [NLANE-1:0]           out_has_dst,
  output logic [NLANE-1:0]           out_elim,
  output logic [NLANE-1:0][PW-1:0]   out_dst_tag,
  output logic [NLANE-1:0][PW-1:0]   out_src1_tag,
  output logic [NLANE-1:0][PW-1:0]   out_src2_tag,
  output logic [NLANE-1:0][PW-1:0]   out_old_tag
);
  import rn_pkg::*;

  logic [NLANE-1:0]         lane_wr, elim;
  logic [NLANE-1:0][PW-1:0] pick, new_tag, s1_tag, s2_tag, old_tag;
  logic [CW-1:0]            avail, need;
  logic [NPHYS-1:0]         ref_free;
  logic                     take, out_hold;

  for (genvar j = 0; j < NLANE; j++) begin : g_lane
    assign lane_wr[j] = in_lane_valid[j] && in_dst_en[j];
    assign elim[j]    = lane_wr[j] && in_is_move[j] && size_wide(in_size[j])
                        && (in_dst[j] != in_src1[j]);
  end

  always_comb begin
    need = '0;
    for (int j = 0; j < NLANE; j++)
      if (lane_wr[j] && !elim[j]) need = need + CW'(1);
  end

  assign out_hold = out_valid && !out_ready;
  assign in_ready = (need <= avail) && !out_hold;
  assign take     = in_valid && in_ready;

  rn_refcnt #(.NPHYS(NPHYS), .NLOG(NLOG), .NLANE(NLANE), .NCMT(NCMT), .REFW(REFW)) u_ref (
    .clk, .rst_n, .take, .lane_wr, .lane_tag(new_tag),
    .cmt_valid, .cmt_tag, .pick, .avail, .ref_free
  );

  rn_map #(.NPHYS(NPHYS), .NLOG(NLOG), .NLANE(NLANE)) u_map (
    .clk, .rst_n, .take, .lane_wr, .elim,
    .dst(in_dst), .src1(in_src1), .src2(in_src2), .pick,
    .new_tag, .s1_tag, .s2_tag, .old_tag
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_lane_valid <= '0;
      out_has_dst    <= '0;
      out_elim       <= '0;
      out_dst_tag    <= '0;
      out_src1_tag   <= '0;
      out_src2_tag   <= '0;
      out_old_tag    <= '0;
    end else if (take) begin
      out_valid      <= 1'b1;
      out_lane_valid <= in_lane_valid;
      out_has_dst    <= lane_wr;
      out_elim       <= elim;
      out_dst_tag    <= new_tag;
      out_src1_tag   <= s1_tag;
      out_src2_tag   <= s2_tag;
      out_old_tag    <= old_tag;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rn_chk.sv
`timescale 1ns/1ps
module rn_chk #(
  parameter int NPHYS = 168,
  parameter int NLANE = 6,
  parameter int PW = 8,
  parameter int LW = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic                     take,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [NLANE-1:0]         in_lane_valid,
  input logic [NLANE-1:0]         in_is_move,
  input logic [NLANE-1:0][2:0]    in_size,
  input logic [NLANE-1:0][LW-1:0] in_dst,
  input logic [NLANE-1:0][LW-1:0] in_src1,
  input logic [NLANE-1:0]         out_lane_valid,
  input logic [NLANE-1:0]         out_has_dst,
  input logic [NLANE-1:0]         out_elim,
  input logic [NLANE-1:0][PW-1:0] out_dst_tag,
  input logic [NLANE-1:0][PW-1:0] out_src1_tag,
  input logic [NPHYS-1:0]         ref_free
);
  logic [NPHYS-1:0] free_q;
  logic             take_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= '0;
      take_q <= 1'b0;
    end else begin
      free_q <= ref_free;
      take_q <= take;
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_dst_tag) && $stable(out_elim)
                               && $stable(out_lane_valid));
  // R10
  hold_blocks_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R8
  stall_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready && out_ready |=> !out_valid);

  for (genvar j = 0; j < NLANE; j++) begin : g_l
    // R3
    elim_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_lane_valid[j] && out_elim[j] |-> out_dst_tag[j] == out_src1_tag[j]);
    // R4
    self_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && in_lane_valid[j] && in_is_move[j] && in_dst[j] == in_src1[j] |=> !out_elim[j]);
    // R5
    narrow_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && in_lane_valid[j] && in_size[j] < 3'd2 |=> !out_elim[j]);
    // R2
    fresh_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && take_q && out_lane_valid[j] && out_has_dst[j] && !out_elim[j]
      |-> free_q[out_dst_tag[j]]);
    for (genvar k = j + 1; k < NLANE; k++) begin : g_p
      // R2
      distinct_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_lane_valid[j] && out_has_dst[j] && !out_elim[j]
        && out_lane_valid[k] && out_has_dst[k] && !out_elim[k]
        |-> out_dst_tag[j] != out_dst_tag[k]);
    end
  end
endmodule

bind rn_top rn_chk #(.NPHYS(NPHYS), .NLANE(NLANE), .PW(PW), .LW(LW)) u_chk (.*);

// File: tb/sim_rn_top.sv
`timescale 1ns/1ps
module sim_rn_top;
  localparam int NL = 2, NLOGV = 8, NPH = 12, NC = 2, PW = 4, LW = 3;

  typedef struct packed { logic v, de, mv; logic [2:0] sz, d, a, b; } lane_t;
  typedef struct packed { logic v, el; logic [3:0] dst, s1, s2, old; } exp_t;
  typedef struct packed {
    lane_t l0, l1; logic [1:0] cv; logic [3:0] c0, c1; logic rdy; exp_t e0, e1;
  } vec_t;

  localparam lane_t NOP = '{0,0,0,0,0,0,0};
  localparam exp_t  NOE = '{0,0,0,0,0,0};
  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{ '{1,1,0,3,1,2,3}, '{1,1,0,3,4,1,5}, 2'b00, 0, 0, 1, '{1,0,8,2,3,1},  '{1,0,9,8,5,4} },
    '{ '{1,1,1,3,6,1,0}, '{1,1,1,2,7,6,0}, 2'b00, 0, 0, 1, '{1,1,8,8,0,6},  '{1,1,8,8,0,7} },
    '{ '{1,1,1,3,2,2,0}, '{1,1,1,1,3,1,0}, 2'b00, 0, 0, 1, '{1,0,10,2,0,2}, '{1,0,11,8,0,3} },
    '{ '{1,1,0,3,5,0,0}, NOP,              2'b11, 1, 2, 0, NOE,             NOE },
    '{ '{1,1,0,3,5,0,0}, '{1,1,1,5,0,5,0}, 2'b00, 0, 0, 1, '{1,0,1,0,0,5},  '{1,1,1,1,0,0} },
    '{ '{1,1,0,3,4,6,7}, NOP,              2'b11, 6, 7, 1, '{1,0,2,8,8,9},  NOE },
    '{ '{1,1,0,3,1,0,0}, '{1,1,0,3,6,1,1}, 2'b11, 8, 8, 1, '{1,0,6,1,1,8},  '{1,0,7,6,6,8} },
    '{ '{1,1,0,3,2,0,0}, NOP,              2'b01, 8, 0, 0, NOE,             NOE },
    '{ '{1,1,0,3,2,0,0}, NOP,              2'b00, 0, 0, 1, '{1,0,8,1,1,10}, NOE }
  };
  string note [NV] = '{"R2 R6 R1", "R3 R6", "R4 R5", "R8 R9", "R3 R6",
                       "R9", "R7 R9", "R9 shared", "R7 R9"};

  logic clk = 0, rst_n = 0, in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [NL-1:0] in_lane_valid = '0, in_dst_en = '0, in_is_move = '0;
  logic [NL-1:0][2:0] in_size = '0;
  logic [NL-1:0][LW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [NC-1:0] cmt_valid = '0;
  logic [NC-1:0][PW-1:0] cmt_tag = '0;
  logic [NL-1:0] out_lane_valid, out_has_dst, out_elim;
  logic [NL-1:0][PW-1:0] out_dst_tag, out_src1_tag, out_src2_tag, out_old_tag;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rn_top #(.NPHYS(NPH), .NLOG(NLOGV), .NLANE(NL), .NCMT(NC), .REFW(6)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_lane(input int j, input lane_t l);
    in_lane_valid[j] = l.v; in_dst_en[j] = l.de; in_is_move[j] = l.mv;
    in_size[j] = l.sz; in_dst[j] = l.d; in_src1[j] = l.a; in_src2[j] = l.b;
  endtask

  task automatic cmp_lane(input int j, input exp_t e, input string n);
    if (!e.v) begin
      chk(out_lane_valid[j] == 1'b0, {n, " lane idle"}, out_lane_valid[j], 0);
    end else begin
      chk(out_lane_valid[j] == 1'b1, {n, " lane valid"}, out_lane_valid[j], 1);
      chk(out_elim[j] == e.el, {n, " R3 elim"}, out_elim[j], e.el);
      chk(out_dst_tag[j] == e.dst, {n, " R2 dst"}, out_dst_tag[j], e.dst);
      chk(out_src1_tag[j] == e.s1, {n, " R6 src1"}, out_src1_tag[j], e.s1);
      chk(out_src2_tag[j] == e.s2, {n, " R6 src2"}, out_src2_tag[j], e.s2);
      chk(out_old_tag[j] == e.old, {n, " R7 old"}, out_old_tag[j], e.old);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    for (int i = 0; i < NV; i++) begin
      set_lane(0, TBL[i].l0); set_lane(1, TBL[i].l1);
      cmt_valid = TBL[i].cv; cmt_tag[0] = TBL[i].c0; cmt_tag[1] = TBL[i].c1;
      in_valid = 1;
      #1;
      chk(in_ready == TBL[i].rdy, {note[i], " in_ready"}, in_ready, TBL[i].rdy);
      @(negedge clk);
      chk(out_valid == TBL[i].rdy, {note[i], " R11 out_valid"}, out_valid, TBL[i].rdy);
      if (TBL[i].rdy) begin
        cmp_lane(0, TBL[i].e0, note[i]);
        cmp_lane(1, TBL[i].e1, note[i]);
      end
    end
    cmt_valid = '0;

    // no register free now; 64-bit move r3 <- r4 (r4 maps to 2, r3 to 11)
    set_lane(0, '{1,1,1,3,3,4,0}); set_lane(1, NOP);
    #1;
    chk(in_ready == 1'b1, "R3 move needs no register", in_ready, 1);
    @(negedge clk);
    out_ready = 0;
    chk(out_valid == 1'b1, "R11 out_valid", out_valid, 1);
    chk(out_dst_tag[0] == 4'd2, "R3 shared dst", out_dst_tag[0], 2);
    chk(out_old_tag[0] == 4'd11, "R7 old", out_old_tag[0], 11);
    #1;
    chk(in_ready == 1'b0, "R10 in_ready under hold", in_ready, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R10 out_valid held", out_valid, 1);
    chk(out_dst_tag[0] == 4'd2, "R10 dst held", out_dst_tag[0], 2);
    out_ready = 1;
    in_valid = 0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 out_valid falls", out_valid, 0);

    // 8-bit move r4 <- r5 needs a register; none free
    set_lane(0, '{1,1,1,0,4,5,0});
    in_valid = 1;
    #1;
    chk(in_ready == 1'b0, "R5 narrow move stalls", in_ready, 0);
    // 128-bit vector move r4 <- r5 (r5 maps to 1)
    set_lane(0, '{1,1,1,4,4,5,0});
    #1;
    chk(in_ready == 1'b1, "R5 vector move accepted", in_ready, 1);
    @(negedge clk);
    in_valid = 0;
    chk(out_elim[0] == 1'b1, "R5 vector move elim", out_elim[0], 1);
    chk(out_dst_tag[0] == 4'd1, "R5 vector move dst", out_dst_tag[0], 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule